// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit sits behind the adder of a small microcontroller ALU. After two packed BCD operands have been added in plain binary, it turns the sum back into valid packed BCD and works out the decimal carry. The data word is split into 4-bit digits, counted from the least significant. When the width is not a multiple of four, the top digit is narrower than the others. The unit is purely combinational. Its outputs follow its inputs within one propagation delay, and it holds no state.

The flag input carries one auxiliary (half) carry for each digit below the top one, and the main carry in its most significant bit. The digits are visited in order from the lowest upward. A digit is corrected when it reads ten or more, or when its flag is set. A correction adds six at that digit's position, or two when the top digit is only two bits wide. The carry out of a correction ripples into the higher digits. A higher digit that wraps from fifteen to zero because of that ripple is marked so that it is corrected in turn. The adder, the flag register, instruction decoding and adjustment after subtraction belong to other blocks.

Top module: `bcd_decimal_adjust`

## Requirements
- R1: The flag vector has (DATA_W-1)/4+1 bits. The top bit is the main carry and bit i below it is the auxiliary carry of digit i. DATA_W defaults to 8, giving flags[1] = carry and flags[0] = auxiliary carry. A set carry input forces the top digit to be corrected.
- R2: Digits are processed from least to most significant. Digit h is corrected by adding 6·16^h when its current 4-bit value, after all lower corrections, is 10 or more, or when flags_in bit h is set.
- R3: A carry out of a correction propagates into the higher digits. Any higher digit that wraps from 15 to 0 on that carry is marked and corrected later. Marks are ORed with the incoming flags.
- R4: A top digit three bits wide is corrected with +6 at its position. It is treated as wrapped by a ripple when all its bits present in the word are ones.
- R5: A top digit two bits wide is corrected with +2 at its position. A top digit one bit wide receives no addition. Only the carry applies to it.
- R6: data_out is the corrected value truncated to DATA_W bits. The carry output is set when the carry input is set or when the corrected value exceeds 2^DATA_W-1.
- R7: The auxiliary-carry bits of flags_out equal those of flags_in.
- R8: The outputs depend only on the present inputs. All-zero inputs give all-zero outputs, and reapplying an input gives the same result whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | DATA_W | Binary sum of two packed BCD operands |
| flags_in | input | (DATA_W-1)/4+1 | Carry (top bit) and per-digit auxiliary carries |
| data_out | output | DATA_W | Decimal-adjusted word |
| flags_out | output | (DATA_W-1)/4+1 | Carry result (top bit) and pass-through auxiliary carries |

## Verification
The bench goes after the chained corrections. Sums such as 0x9A, 0xFA and 0x99A force one digit's correction to push the next digit over nine or wrap it through zero. A unit that does not ripple, or that forgets to mark the wrapped digit, leaves a hex digit in the output or drops the carry. Words with a top digit three, two and one bit wide come next: a wrong addend or threshold there shows up as a top digit off by four or two, or as a missing carry out. A set carry input on an already valid word must still add six to the top digit. A unit that ignores the incoming flags returns the word unchanged.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    // Width class of one digit of the word
    typedef enum logic [1:0] {
        NIB_FULL  = 2'd0,
        NIB_THREE = 2'd1,
        NIB_TWO   = 2'd2,
        NIB_ONE   = 2'd3
    } nib_kind_e;

    function automatic int nib_count(input int width);
        return (width - 1) / 4 + 1;
    endfunction

    function automatic nib_kind_e kind_of(input int width, input int idx);
        int left;
        left = width - 4 * idx;
        if (left >= 4)      return NIB_FULL;
        else if (left == 3) return NIB_THREE;
        else if (left == 2) return NIB_TWO;
        else                return NIB_ONE;
    endfunction

endpackage

// File: rtl/dadj_stage.sv
module dadj_stage
    import dadj_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX    = 0,
    parameter int NIB    = 2,
    parameter int XW     = 9
) (
    input  logic [XW-1:0]  x_in,
    input  logic [NIB-1:0] f_in,
    output logic [XW-1:0]  x_out,
    output logic [NIB-1:0] f_out
);

    localparam nib_kind_e KIND = kind_of(DATA_W, IDX);
    localparam logic [XW-1:0] ADDEND =
        (KIND == NIB_FULL || KIND == NIB_THREE) ? (XW'(6) << (4 * IDX)) :
        (KIND == NIB_TWO)                       ? (XW'(2) << (4 * IDX)) :
                                                  '0;
    // data bits of the top digit that lie inside the word
    localparam logic [XW-1:0] TOP_MASK =
        ((XW'(1) << DATA_W) - XW'(1)) & ~((XW'(1) << (4 * (NIB - 1))) - XW'(1));

    logic           fire;
    logic [NIB-1:0] mark;

    always_comb begin
        logic       prev;
        logic       b;
        logic [3:0] nk;
        fire = (x_in[4*IDX +: 4] >= 4'd10) || f_in[IDX];
        mark = '0;
        prev = 1'b0;
        for (int k = 0; k < NIB; k++) begin
            nk = x_in[4*k +: 4];
            b  = 1'b0;
            if (k == IDX) begin
                unique case (KIND)
                    NIB_FULL:           b = (nk >= 4'd10);
                    NIB_THREE, NIB_TWO: b = (nk >= 4'd2);
                    default:            b = 1'b0;
                endcase
            end else if (k > IDX) begin
                if (kind_of(DATA_W, k) == NIB_FULL)
                    b = (nk == 4'hF) && prev;
                else
                    b = ((x_in & TOP_MASK) == TOP_MASK) && prev;
            end
            prev    = b;
            mark[k] = b;
        end
    end

    assign x_out = fire ? (x_in + ADDEND) : x_in;
    assign f_out = fire ? (f_in | mark) : f_in;

endmodule

// File: rtl/dadj_finish.sv
module dadj_finish #(
    parameter int DATA_W = 8,
    parameter int XW     = 9
) (
    input  logic [XW-1:0]     x_fin,
    input  logic              cy_in,
    output logic [DATA_W-1:0] data_out,
    output logic              cy_out
);

    assign data_out = x_fin[DATA_W-1:0];
    assign cy_out   = cy_in | (|x_fin[XW-1:DATA_W]);

endmodule

// File: rtl/bcd_decimal_adjust.sv
module bcd_decimal_adjust
    import dadj_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]       data_in,
    input  logic [(DATA_W-1)/4:0]   flags_in,
    output logic [DATA_W-1:0]       data_out,
    output logic [(DATA_W-1)/4:0]   flags_out
);

    localparam int NIB = nib_count(DATA_W);
    localparam int XW  = 4 * NIB + 1;

    logic [XW-1:0]  x_chain [0:NIB];
    logic [NIB-1:0] f_chain [0:NIB];
    logic           cy_res;

    assign x_chain[0] = XW'(data_in);
    assign f_chain[0] = flags_in;

    for (genvar h = 0; h < NIB; h++) begin : g_stage
        dadj_stage #(
            .DATA_W (DATA_W),
            .IDX    (h),
            .NIB    (NIB),
            .XW     (XW)
        ) u_stage (
            .x_in  (x_chain[h]),
            .f_in  (f_chain[h]),
            .x_out (x_chain[h+1]),
            .f_out (f_chain[h+1])
        );

        always_comb begin
            // R3: marks only accumulate and the value only grows along the chain
            p_flags_grow_r3: assert ((f_chain[h+1] & f_chain[h]) == f_chain[h]);
            p_value_grow_r3: assert (x_chain[h+1] >= x_chain[h]);
        end
    end

    dadj_finish #(
        .DATA_W (DATA_W),
        .XW     (XW)
    ) u_finish (
        .x_fin    (x_chain[NIB]),
        .cy_in    (flags_in[NIB-1]),
        .data_out (data_out),
        .cy_out   (cy_res)
    );

    if (NIB > 1) begin : g_aux
        assign flags_out = {cy_res, flags_in[NIB-2:0]};

        always_comb begin
            if (!flags_in[0])
                p_low_digit_r2: assert (data_out[3:0] <= 4'd9);
        end
    end else begin : g_noaux
        assign flags_out = cy_res;
    end

    always_comb begin
        logic all_dec;
        all_dec = 1'b1;
        for (int k = 0; k < NIB; k++)
            if (x_chain[0][4*k +: 4] > 4'd9) all_dec = 1'b0;
        if (flags_in[NIB-1])
            p_carry_keep_r6: assert (flags_out[NIB-1]);
        if (all_dec && flags_in == '0)
            p_passthrough_r2: assert (data_out == data_in && !flags_out[NIB-1]);
    end

endmodule

// File: tb/bcd_decimal_adjust_bench.sv
module bcd_decimal_adjust_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  d8;  logic [1:0] f8;  logic [7:0]  q8;  logic [1:0] g8;
    logic [4:0]  d5;  logic [1:0] f5;  logic [4:0]  q5;  logic [1:0] g5;
    logic [5:0]  d6;  logic [1:0] f6;  logic [5:0]  q6;  logic [1:0] g6;
    logic [6:0]  d7;  logic [1:0] f7;  logic [6:0]  q7;  logic [1:0] g7;
    logic [11:0] d12; logic [2:0] f12; logic [11:0] q12; logic [2:0] g12;

    bcd_decimal_adjust u_bcd_decimal_adjust (.data_in(d8), .flags_in(f8), .data_out(q8), .flags_out(g8));
    bcd_decimal_adjust #(.DATA_W(5))  u_w5  (.data_in(d5),  .flags_in(f5),  .data_out(q5),  .flags_out(g5));
    bcd_decimal_adjust #(.DATA_W(6))  u_w6  (.data_in(d6),  .flags_in(f6),  .data_out(q6),  .flags_out(g6));
    bcd_decimal_adjust #(.DATA_W(7))  u_w7  (.data_in(d7),  .flags_in(f7),  .data_out(q7),  .flags_out(g7));
    bcd_decimal_adjust #(.DATA_W(12)) u_w12 (.data_in(d12), .flags_in(f12), .data_out(q12), .flags_out(g12));

    // Arithmetic model of the requirements
    function automatic void model(input int w, input int din, input int fin,
                                  output int dout, output int fout);
        int n, f, fi, nb, nk, mask;
        longint v;
        bit prev, b, cy;
        n = (w - 1) / 4 + 1;
        v = din;
        f = fin;
        mask = (1 << w) - 1;
        for (int h = 0; h < n; h++) begin
            nb = int'((v >> (4 * h)) & 15);
            if (nb >= 10 || ((f >> h) & 1) == 1) begin
                fi = 0;
                prev = 1'b0;
                for (int k = h; k < n; k++) begin
                    nk = int'((v >> (4 * k)) & 15);
                    if (k == h) begin
                        if (w >= 4 * k + 4)                        b = (nk >= 10);
                        else if (w == 4 * k + 3 || w == 4 * k + 2) b = (nk >= 2);
                        else                                       b = 1'b0;
                    end else if (w >= 4 * k + 4) begin
                        b = (nk == 15) && prev;
                    end else begin
                        b = ((v % (longint'(1) << w)) >=
                             (longint'((1 << (w - 4 * k)) - 1) << (4 * k))) && prev;
                    end
                    prev = b;
                    if (b) fi = fi | (1 << k);
                end
                if (w >= 4 * h + 3)      v = v + (longint'(6) << (4 * h));
                else if (w == 4 * h + 2) v = v + (longint'(2) << (4 * h));
                f = f | fi;
            end
        end
        dout = int'(v) & mask;
        cy = (((fin >> (n - 1)) & 1) == 1) || (v > mask);
        fout = (int'(cy) << (n - 1)) | (fin & ((1 << (n - 1)) - 1));
    endfunction

    task automatic apply(input int w, input int d, input int f);
        case (w)
            5:  begin d5  = 5'(d);  f5  = 2'(f); end
            6:  begin d6  = 6'(d);  f6  = 2'(f); end
            7:  begin d7  = 7'(d);  f7  = 2'(f); end
            8:  begin d8  = 8'(d);  f8  = 2'(f); end
            default: begin d12 = 12'(d); f12 = 3'(f); end
        endcase
    endtask

    task automatic observe(input int w, output int qd, output int qf);
        case (w)
            5:  begin qd = int'(q5);  qf = int'(g5);  end
            6:  begin qd = int'(q6);  qf = int'(g6);  end
            7:  begin qd = int'(q7);  qf = int'(g7);  end
            8:  begin qd = int'(q8);  qf = int'(g8);  end
            default: begin qd = int'(q12); qf = int'(g12); end
        endcase
    endtask

    task automatic compare(input string req, input int w, input int d, input int f,
                           input int ed, input int ef);
        int qd, qf;
        observe(w, qd, qf);
        checks++;
        if (qd != ed || qf != ef) begin
            failures++;
            $display("FAIL %s w=%0d in=%h/%b got data=%h flags=%b expected data=%h flags=%b",
                     req, w, d, f, qd, qf, ed, ef);
        end
    endtask

    task automatic directed(input string req, input int w, input int d, input int f,
                            input int ed, input int ef);
        @(posedge clk);
        apply(w, d, f);
        @(negedge clk);
        compare(req, w, d, f, ed, ef);
    endtask

    initial begin
        int ws [5] = '{5, 6, 7, 8, 12};
        apply(5, 0, 0); apply(6, 0, 0); apply(7, 0, 0); apply(8, 0, 0); apply(12, 0, 0);

        // R8: all-zero inputs give all-zero outputs
        directed("R8", 8, 'h00, 'b00, 'h00, 'b00);
        // R1: carry input alone corrects the top digit
        directed("R1", 8, 'h00, 'b10, 'h60, 'b10);
        // R2: low digit over nine, and a flagged low digit
        directed("R2", 8, 'h0A, 'b00, 'h10, 'b00);
        directed("R2", 8, 'h09, 'b01, 'h0F, 'b01);
        // R3: ripple pushes next digit over nine; ripple wraps next digit
        directed("R3", 8, 'h9A, 'b00, 'h00, 'b10);
        directed("R3", 8, 'hFA, 'b00, 'h60, 'b10);
        directed("R3", 12, 'h99A, 'b000, 'h000, 'b100);
        // R6: valid word stays, carry input adds six on top
        directed("R6", 8, 'h99, 'b00, 'h99, 'b00);
        directed("R6", 8, 'h99, 'b10, 'hF9, 'b10);
        // R7: auxiliary carry passes through
        directed("R7", 8, 'h00, 'b01, 'h06, 'b01);
        // R4: three-bit top digit
        directed("R4", 7, 'h7A, 'b00, 'h60, 'b10);
        directed("R4", 7, 'h10, 'b10, 'h70, 'b10);
        // R5: two-bit and one-bit top digits
        directed("R5", 6, 'h05, 'b10, 'h25, 'b10);
        directed("R5", 5, 'h05, 'b10, 'h05, 'b10);
        // R8: same input after a different one gives the same result
        directed("R8", 8, 'h9A, 'b00, 'h00, 'b10);
        directed("R8", 8, 'h33, 'b01, 'h39, 'b01);
        directed("R8", 8, 'h9A, 'b00, 'h00, 'b10);

        // Exhaustive sweep of every width: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 32768; i++) begin
            @(posedge clk);
            foreach (ws[j]) begin
                int nb = (ws[j] - 1) / 4 + 1;
                if (i < (1 << (ws[j] + nb)))
                    apply(ws[j], (i >> nb) & ((1 << ws[j]) - 1), i & ((1 << nb) - 1));
            end
            @(negedge clk);
            foreach (ws[j]) begin
                int nb = (ws[j] - 1) / 4 + 1;
                int d, f, ed, ef;
                if (i < (1 << (ws[j] + nb))) begin
                    d = (i >> nb) & ((1 << ws[j]) - 1);
                    f = i & ((1 << nb) - 1);
                    model(ws[j], d, f, ed, ef);
                    compare("R2/R3/R4/R5/R6/R7 sweep", ws[j], d, f, ed, ef);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule